// File: doc/BRIEF.md
# Circular Buffer Pointer Updater

This block is the address-update engine for a circular buffer. It holds three registers: the current pointer and the two buffer limits, called the start and end addresses. On each enabled cycle it steps the pointer up or down by an unsigned step magnitude. When the stepped pointer leaves the buffer, the block moves it back in by one buffer length, so successive accesses wrap around the region.

The limits may be given in either order. A start address below the end address describes the same region as one above it, and the size and wrap correction are worked out for each ordering. Separate load strobes write the pointer, the start and the end. The block outputs the current pointer and the buffer length, and both outputs come straight from registers.

Top module: `circ_ptr_updater`

## Requirements
- R1: After a cycle with `rst` high, `ptr_out` is 0, both limits are 0 and `buf_size` is 1.
- R2: When `ptr_load` is high, `ptr_out` equals `ptr_load_val` on the next cycle, even if `upd_en` is also high in that cycle.
- R3: With `ptr_load` and `upd_en` both low, `ptr_out` keeps its value.
- R4: `buf_size` equals the absolute difference of the two limits plus one, for either ordering. It shows newly loaded limits one cycle after the load.
- R5: An update forms a tentative pointer. `step_down`=0 adds `step`, and `step_down`=1 subtracts it. If the tentative pointer lies between the lower and upper limit inclusive, it is taken unchanged.
- R6: With start < end, a tentative pointer above end has `buf_size` subtracted, and one below start has `buf_size` added.
- R7: With start > end, a tentative pointer above start has `buf_size` subtracted, and one below end has `buf_size` added.
- R8: A tentative pointer that passes above the largest address or below zero is detected and wrapped as in R6/R7. This also holds for a buffer covering the whole address space, whose `buf_size` is 2^ADDR_W.
- R9: When start equals end, an update leaves the pointer at that address for any step.
- R10: An update in the same cycle as a start or end load uses the old limits. The new limits apply from the next update on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_load | input | 1 | Write `ptr_load_val` into the pointer |
| ptr_load_val | input | ADDR_W | Pointer load value |
| start_load | input | 1 | Write `start_val` into the start limit |
| start_val | input | ADDR_W | Start address value |
| end_load | input | 1 | Write `end_val` into the end limit |
| end_val | input | ADDR_W | End address value |
| upd_en | input | 1 | Perform a pointer update this cycle |
| step | input | ADDR_W | Step magnitude (at most `buf_size` for a correct wrap) |
| step_down | input | 1 | 0 = add step, 1 = subtract step |
| ptr_out | output | ADDR_W | Current pointer |
| buf_size | output | ADDR_W+1 | Current buffer length |

## Verification
The update path is driven in six settings:
- A rising-order buffer stepped both ways. This separates the add and subtract corrections from the pass-through case.
- A step exactly equal to the buffer length. This exercises the boundary of the correction.
- The same stepping on a falling-order buffer. This shows that the limits are swapped correctly rather than compared in raw order.
- Buffers pressed against the top and bottom of the address space, and one spanning all of it. These expose any comparison that loses the carry or borrow.
- Same-cycle load-and-update combinations and a single-address buffer. These pin down priority and the degenerate hold.
- A long run of random legal steps on random limits, compared every cycle against the bench model.

// File: rtl/circ_ptr_pkg.sv
package circ_ptr_pkg;
  typedef enum logic {ORD_RISING = 1'b0, ORD_FALLING = 1'b1} buf_order_e;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} step_dir_e;
endpackage

// File: rtl/circ_limit_regs.sv
module circ_limit_regs
  import circ_ptr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_load,
  input  logic [ADDR_W-1:0] start_val,
  input  logic              end_load,
  input  logic [ADDR_W-1:0] end_val,
  output logic [ADDR_W-1:0] start_q,
  output logic [ADDR_W-1:0] end_q,
  output logic [ADDR_W-1:0] lo_q,
  output logic [ADDR_W-1:0] hi_q,
  output logic [ADDR_W:0]   size_q
);
  localparam int SW = ADDR_W + 1;

  logic [ADDR_W-1:0] start_d, end_d, lo_d, hi_d;
  logic [SW-1:0]     size_fwd, size_rev, size_d;
  buf_order_e        order_d;

  always_comb begin
    start_d  = start_load ? start_val : start_q;
    end_d    = end_load ? end_val : end_q;
    order_d  = (start_d > end_d) ? ORD_FALLING : ORD_RISING;
    size_fwd = {1'b0, end_d} - {1'b0, start_d} + SW'(1);
    size_rev = {1'b0, start_d} - {1'b0, end_d} + SW'(1);
    if (order_d == ORD_FALLING) begin
      size_d = size_rev;
      lo_d   = end_d;
      hi_d   = start_d;
    end else begin
      size_d = size_fwd;
      lo_d   = start_d;
      hi_d   = end_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      end_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      size_q  <= SW'(1);
    end else begin
      start_q <= start_d;
      end_q   <= end_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      size_q  <= size_d;
    end
  end
endmodule

// File: rtl/circ_wrap_calc.sv
module circ_wrap_calc
  import circ_ptr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cur_ptr,
  input  logic [ADDR_W-1:0] step,
  input  logic              step_down,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W:0]   size,
  output logic [ADDR_W-1:0] next_ptr
);
  localparam int EW = ADDR_W + 2;

  logic [EW-1:0] cur_e, step_e, lo_e, hi_e, size_e, tent, fixed;
  logic          neg, above, below, single;
  step_dir_e     dir;

  always_comb begin
    dir    = step_dir_e'(step_down);
    cur_e  = {2'b00, cur_ptr};
    step_e = {2'b00, step};
    lo_e   = {2'b00, lo};
    hi_e   = {2'b00, hi};
    size_e = {1'b0, size};
    single = (size == (ADDR_W+1)'(1));
    tent   = (dir == DIR_DOWN) ? (cur_e - step_e) : (cur_e + step_e);
    neg    = tent[EW-1];
    below  = neg || (tent < lo_e);
    above  = !neg && (tent > hi_e);
    if (single)     fixed = lo_e;
    else if (below) fixed = tent + size_e;
    else if (above) fixed = tent - size_e;
    else            fixed = tent;
    next_ptr = fixed[ADDR_W-1:0];
  end
endmodule

// File: rtl/circ_ptr_updater.sv
module circ_ptr_updater #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_load_val,
  input  logic              start_load,
  input  logic [ADDR_W-1:0] start_val,
  input  logic              end_load,
  input  logic [ADDR_W-1:0] end_val,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] step,
  input  logic              step_down,
  output logic [ADDR_W-1:0] ptr_out,
  output logic [ADDR_W:0]   buf_size
);
  logic [ADDR_W-1:0] lim_start, lim_end, lim_lo, lim_hi, ptr_q, ptr_next;
  logic [ADDR_W:0]   lim_size;

  circ_limit_regs #(.ADDR_W(ADDR_W)) u_lim (
    .clk        (clk),
    .rst        (rst),
    .start_load (start_load),
    .start_val  (start_val),
    .end_load   (end_load),
    .end_val    (end_val),
    .start_q    (lim_start),
    .end_q      (lim_end),
    .lo_q       (lim_lo),
    .hi_q       (lim_hi),
    .size_q     (lim_size)
  );

  circ_wrap_calc #(.ADDR_W(ADDR_W)) u_wrap (
    .cur_ptr   (ptr_q),
    .step      (step),
    .step_down (step_down),
    .lo        (lim_lo),
    .hi        (lim_hi),
    .size      (lim_size),
    .next_ptr  (ptr_next)
  );

  always_ff @(posedge clk) begin
    if (rst)           ptr_q <= '0;
    else if (ptr_load) ptr_q <= ptr_load_val;
    else if (upd_en)   ptr_q <= ptr_next;
  end

  assign ptr_out  = ptr_q;
  assign buf_size = lim_size;
endmodule

// File: rtl/circ_ptr_checker.sv
module circ_ptr_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ptr_load,
  input logic [ADDR_W-1:0] ptr_load_val,
  input logic              start_load,
  input logic [ADDR_W-1:0] start_val,
  input logic              end_load,
  input logic [ADDR_W-1:0] end_val,
  input logic              upd_en,
  input logic [ADDR_W-1:0] step,
  input logic [ADDR_W-1:0] ptr_out,
  input logic [ADDR_W:0]   buf_size,
  input logic [ADDR_W-1:0] start_r,
  input logic [ADDR_W-1:0] end_r
);
  logic [ADDR_W-1:0] c_lo, c_hi, in_lo, in_hi;
  logic [ADDR_W:0]   in_diff1;

  always_comb begin
    c_lo     = (start_r < end_r) ? start_r : end_r;
    c_hi     = (start_r < end_r) ? end_r : start_r;
    in_lo    = (start_val < end_val) ? start_val : end_val;
    in_hi    = (start_val < end_val) ? end_val : start_val;
    in_diff1 = {1'b0, in_hi} - {1'b0, in_lo} + (ADDR_W+1)'(1);
  end

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (ptr_out == '0 && buf_size == (ADDR_W+1)'(1)));

  // R2
  a_r2_load_wins: assert property (@(posedge clk) disable iff (rst)
    ptr_load |=> (ptr_out == $past(ptr_load_val)));

  // R3
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!ptr_load && !upd_en) |=> $stable(ptr_out));

  // R4
  a_r4_size_after_load: assert property (@(posedge clk) disable iff (rst)
    (start_load && end_load) |=> (buf_size == $past(in_diff1)));

  // R6 R7 R8
  a_r6_stays_inside: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !ptr_load && ptr_out >= c_lo && ptr_out <= c_hi &&
     {1'b0, step} <= buf_size)
    |=> (ptr_out >= $past(c_lo) && ptr_out <= $past(c_hi)));

  // R9
  a_r9_single_hold: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !ptr_load && start_r == end_r)
    |=> (ptr_out == $past(start_r)));
endmodule

bind circ_ptr_updater circ_ptr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ptr_load     (ptr_load),
  .ptr_load_val (ptr_load_val),
  .start_load   (start_load),
  .start_val    (start_val),
  .end_load     (end_load),
  .end_val      (end_val),
  .upd_en       (upd_en),
  .step         (step),
  .ptr_out      (ptr_out),
  .buf_size     (buf_size),
  .start_r      (lim_start),
  .end_r        (lim_end)
);

// File: tb/tb_circ_ptr_updater.sv
`timescale 1ns/1ps
module tb_circ_ptr_updater;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          ptr_load, start_load, end_load, upd_en, step_down;
  logic [AW-1:0] ptr_load_val, start_val, end_val, step;
  logic [AW-1:0] ptr_out;
  logic [AW:0]   buf_size;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  int m_ptr, m_start, m_end;

  always #10 clk = ~clk;

  circ_ptr_updater #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst),
    .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
    .start_load(start_load), .start_val(start_val),
    .end_load(end_load), .end_val(end_val),
    .upd_en(upd_en), .step(step), .step_down(step_down),
    .ptr_out(ptr_out), .buf_size(buf_size)
  );

  function automatic int m_size();
    return ((m_start > m_end) ? (m_start - m_end) : (m_end - m_start)) + 1;
  endfunction

  function automatic int m_next(int st, bit dn);
    int lo, hi, sz, t;
    lo = (m_start < m_end) ? m_start : m_end;
    hi = (m_start < m_end) ? m_end : m_start;
    sz = m_size();
    t  = dn ? (m_ptr - st) : (m_ptr + st);
    if (sz == 1)     t = lo;
    else if (t > hi) t = t - sz;
    else if (t < lo) t = t + sz;
    return t;
  endfunction

  task automatic compare(string tag);
    n_cmp++;
    if (ptr_out !== AW'(m_ptr) || buf_size !== (AW+1)'(m_size())) begin
      n_bad++;
      $display("FAIL %s: ptr=%h size=%h expected ptr=%h size=%h",
               tag, ptr_out, buf_size, AW'(m_ptr), (AW+1)'(m_size()));
    end
  endtask

  // one clock: drive at negedge, advance model, compare at next negedge
  task automatic cyc(bit pl, int pv, bit sl, int sv, bit el, int ev,
                     bit ue, int st, bit dn, string tag);
    int nxt;
    ptr_load = pl; ptr_load_val = AW'(pv);
    start_load = sl; start_val = AW'(sv);
    end_load = el; end_val = AW'(ev);
    upd_en = ue; step = AW'(st); step_down = dn;
    nxt = m_next(st, dn);
    if (pl)      m_ptr = pv;
    else if (ue) m_ptr = nxt;
    if (sl) m_start = sv;
    if (el) m_end = ev;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic upd(int st, bit dn, string tag);
    cyc(0, 0, 0, 0, 0, 0, 1, st, dn, tag);
  endtask

  task automatic setup(int s, int e, int p, string tag);
    cyc(0, 0, 1, s, 1, e, 0, 0, 0, tag);
    cyc(1, p, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(4_000_000ns);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    ptr_load = 0; start_load = 0; end_load = 0; upd_en = 0; step_down = 0;
    ptr_load_val = '0; start_val = '0; end_val = '0; step = '0;
    m_ptr = 0; m_start = 0; m_end = 0;
    @(negedge clk); @(negedge clk);
    compare("R1 reset");
    rst = 1'b0;

    // R4, R2: rising buffer 0x100..0x10F
    setup('h100, 'h10F, 'h100, "R4 R2 rising setup");
    // R5 pass-through, R6 above end
    for (int i = 0; i < 7; i++) upd(3, 0, "R5 R6 up by 3");
    // R6 below start
    for (int i = 0; i < 5; i++) upd(5, 1, "R6 down by 5");
    upd(16, 0, "R6 step equals size");
    upd(16, 1, "R6 step equals size down");
    // R2 load beats update
    cyc(1, 'h10A, 0, 0, 0, 0, 1, 4, 0, "R2 load with update");
    // R3 idle
    cyc(0, 'h555, 0, 0, 0, 0, 0, 9, 1, "R3 idle");
    cyc(0, 'h555, 0, 0, 0, 0, 0, 9, 0, "R3 idle");

    // R10: end load and update together use old limits
    cyc(1, 'h10E, 0, 0, 0, 0, 0, 0, 0, "R10 prep");
    cyc(0, 0, 0, 0, 1, 'h11F, 1, 4, 0, "R10 old limits");
    upd(15, 0, "R10 new limits");

    // R7: falling order 0x210 start, 0x200 end
    setup('h210, 'h200, 'h205, "R4 R7 falling setup");
    for (int i = 0; i < 6; i++) upd(4, 0, "R7 up past start");
    for (int i = 0; i < 6; i++) upd(7, 1, "R7 down past end");
    upd(17, 1, "R7 step equals size");

    // R8: top of address space
    setup('hFFF0, 'hFFFF, 'hFFFE, "R8 top setup");
    upd(4, 0, "R8 overflow past max");
    upd(16, 0, "R8 overflow full step");
    setup('hFFFF, 'hFFF8, 'hFFFC, "R8 falling top setup");
    upd(6, 0, "R8 falling overflow");
    // R8: bottom
    setup('h0000, 'h0007, 'h0001, "R8 bottom setup");
    upd(3, 1, "R8 underflow below zero");
    upd(8, 1, "R8 underflow full step");
    setup('h0007, 'h0000, 'h0002, "R8 falling bottom setup");
    upd(5, 1, "R8 falling underflow");
    // R8: whole address space
    setup('h0000, 'hFFFF, 'hFFFF, "R4 R8 full space setup");
    upd(1, 0, "R8 full space wrap up");
    upd(2, 1, "R8 full space wrap down");
    upd(65535, 0, "R8 full space big step");

    // R9: single-address buffer
    setup('h0050, 'h0050, 'h0050, "R9 setup");
    upd(7, 0, "R9 hold up");
    upd(1, 1, "R9 hold down");
    upd(0, 0, "R9 hold zero step");

    // random legal traffic across R4..R10
    for (int k = 0; k < 40; k++) begin
      int s, e, sz, lo;
      s = int'($urandom_range(0, 65535));
      e = int'($urandom_range(0, 65535));
      if ((k % 4) == 0) e = (s + int'($urandom_range(0, 40))) % 65536;
      sz = ((s > e) ? (s - e) : (e - s)) + 1;
      lo = (s < e) ? s : e;
      setup(s, e, lo + int'($urandom_range(0, sz - 1)), "R4 random setup");
      for (int j = 0; j < 25; j++) begin
        int st;
        st = int'($urandom_range(0, (sz > 65535) ? 65535 : sz));
        upd(st, bit'($urandom_range(0, 1)), "R5 R6 R7 random step");
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule